// File: doc/BRIEF.md
# Lockable Set-Associative Cache Controller

This block controls one set-associative cache. Each way holds a tag, a line of data, and valid, dirty, locked and rank state. The block serves single commands: read a line, write one byte, preload a span of lines (locking them if asked), unlock a line, invalidate one line, and invalidate the whole cache. The last two can write back dirty data first. A mode input picks write-through or copy-back handling of writes.

Line fills, write-backs and single-byte memory writes use one request/acknowledge memory port. The port carries a whole line with a byte-enable mask. Addresses with the top address bit set are non-cacheable and go straight to memory.

A locked way is never chosen as a victim. When every way of the indexed set is locked, a miss does not allocate a line.

Top module: `lock_cache_ctrl`

## Requirements
- R1: On a miss, the victim is always an unlocked way. When all ways of the set are locked, nothing is allocated. A read then ends with `cmd_fail`=1 and `cmd_hit`=0. A write then ends with `cmd_fail`=1 and its byte is written straight to memory.
- R2: A read (op 0) that misses fills the line from memory and returns it on `rd_line` with `cmd_hit`=0. The filled line is clean. A repeated read of the same line returns `cmd_hit`=1.
- R3: A write (op 1) places `cmd_wbyte` in byte lane `o` of the line, bits [8*o+7:8*o], where `o` is the address offset. A hit always updates the line. A miss in copy-back mode first fills the line, then merges the byte and marks the line dirty.
- R4: Every hit or fill makes the line the most recently used in its set. The victim is the lowest-index invalid unlocked way if there is one, otherwise the unlocked way used least recently.
- R5: In write-through mode (`copy_back`=0), every cacheable write also sends its byte to memory, with a one-hot `mem_be` at the offset. A write-through miss allocates nothing.
- R6: In copy-back mode, evicting a dirty victim writes the whole line back to memory before the fill.
- R7: A preload (op 2) treats a length of 0 as 1. It touches 1 + (offset + length - 1) / line_bytes consecutive lines, filling any that are missing. When `cmd_lock`=1 it locks each line it touches.
- R8: An unlock (op 3) clears the locked bit only on a hit. It reports `cmd_hit`=0 and changes nothing on a miss.
- R9: An invalidate (op 4) that hits writes the line back first only if it is dirty and `cmd_flush`=1. It then makes the line invalid and unlocked, and moves it to least-recently-used rank.
- R10: An invalidate-all (op 5) writes back every valid dirty line when `cmd_flush`=1. It leaves every way invalid and unlocked.
- R11: `cmd_ready` is high only when the block is idle. Each accepted command ends with a `cmd_done` pulse exactly one cycle wide, and the status outputs are valid during that pulse.
- R12: An address with bit ADDR_W-1 set is non-cacheable. A read of it fetches the line from memory without allocating; a write of it goes straight to memory.
- R13: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen. Line operations use line-aligned addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, taken while `cmd_ready` is high |
| cmd_ready | output | 1 | Idle, ready for a command |
| cmd_op | input | 3 | 0 read, 1 write, 2 preload, 3 unlock, 4 invalidate, 5 invalidate-all |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wbyte | input | 8 | Write byte |
| cmd_len | input | LEN_W | Preload length in bytes |
| cmd_lock | input | 1 | Lock lines touched by a preload |
| cmd_flush | input | 1 | Write back dirty lines on invalidate |
| copy_back | input | 1 | 1 copy-back, 0 write-through |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_hit | output | 1 | Every line the command looked up was present |
| cmd_fail | output | 1 | A needed allocation was blocked by locks |
| rd_line | output | 8*LINE_BYTES | Line returned by a read |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address, line aligned |
| mem_be | output | LINE_BYTES | Byte enables of a memory write |
| mem_wline | output | 8*LINE_BYTES | Memory write data |
| mem_rline | input | 8*LINE_BYTES | Memory read data, taken with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge, one cycle |

## Verification
Some properties are checked on every cycle:
- A fill never lands in a locked way.
- A lookup that finds every way locked never moves on to a fill.
- Every hit or allocation leaves the way at the top rank.
- `cmd_done` lasts one cycle.
- A pending memory request keeps its address until acknowledged.

Other behaviour can only be shown by scenarios that compare memory contents and returned lines with values worked out from the requirements:
- byte-lane merging;
- the write-through and copy-back paths;
- least-recently-used replacement order;
- the preload line count;
- the effect of flush on the two invalidates;
- unlocking that frees a way for replacement.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_PRELOAD = 3'd2,
        OP_UNLOCK  = 3'd3,
        OP_INVAL   = 3'd4,
        OP_INVALL  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_WB,
        S_FILL,
        S_MWR,
        S_NCRD,
        S_WALK,
        S_DONE
    } state_e;

endpackage

// File: rtl/cc_victim.sv
module cc_victim #(
    parameter int WAYS   = 4,
    parameter int RANK_W = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0]             way_locked,
    input  logic [WAYS-1:0][RANK_W-1:0] way_rank,
    output logic                        found,
    output logic [WAY_W-1:0]            way
);
    logic [RANK_W-1:0] best;
    logic              took_free;

    always_comb begin
        found     = 1'b0;
        way       = '0;
        best      = '1;
        took_free = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!way_locked[i]) begin
                if (!way_valid[i]) begin
                    if (!took_free) begin
                        way       = WAY_W'(i);
                        took_free = 1'b1;
                        found     = 1'b1;
                    end
                end else if (!took_free && (!found || way_rank[i] < best)) begin
                    way   = WAY_W'(i);
                    best  = way_rank[i];
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cc_rank.sv
module cc_rank #(
    parameter int WAYS   = 4,
    parameter int RANK_W = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][RANK_W-1:0] rank_in,
    input  logic [WAY_W-1:0]            sel,
    output logic [WAYS-1:0][RANK_W-1:0] promoted,
    output logic [WAYS-1:0][RANK_W-1:0] demoted
);
    logic [RANK_W-1:0] old_rank;
    assign old_rank = rank_in[sel];

    for (genvar g = 0; g < WAYS; g++) begin : g_lane
        always_comb begin
            if (WAY_W'(g) == sel) begin
                promoted[g] = RANK_W'(WAYS);
                demoted[g]  = '0;
            end else begin
                promoted[g] = (rank_in[g] > old_rank) ? rank_in[g] - 1'b1 : rank_in[g];
                demoted[g]  = (rank_in[g] != '0 && rank_in[g] < old_rank)
                              ? rank_in[g] + 1'b1 : rank_in[g];
            end
        end
    end
endmodule

// File: rtl/lock_cache_ctrl.sv
module lock_cache_ctrl
    import cc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 4,
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int LEN_W      = 8,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int LINE_W = 8 * LINE_BYTES,
    localparam int RANK_W = $clog2(WAYS + 1),
    localparam int WALK_W = SET_W + WAY_W,
    localparam int CNT_W  = LEN_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [2:0]            cmd_op,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [7:0]            cmd_wbyte,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic                  cmd_lock,
    input  logic                  cmd_flush,
    input  logic                  copy_back,
    output logic                  cmd_done,
    output logic                  cmd_hit,
    output logic                  cmd_fail,
    output logic [LINE_W-1:0]     rd_line,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_BYTES-1:0] mem_be,
    output logic [LINE_W-1:0]     mem_wline,
    input  logic [LINE_W-1:0]     mem_rline,
    input  logic                  mem_ack
);
    typedef struct {
        state_e                      st;
        op_e                         op;
        logic [ADDR_W-1:0]           addr;
        logic [7:0]                  wbyte;
        logic                        lock;
        logic                        flush;
        logic                        cb;
        logic                        miss;
        logic                        fail;
        logic [CNT_W-1:0]            lines;
        logic [WALK_W-1:0]           walk;
        logic [WAY_W-1:0]            way;
        logic [LINE_W-1:0]           rline;
        logic [TAG_W-1:0]            tag  [SETS][WAYS];
        logic [LINE_W-1:0]           data [SETS][WAYS];
        logic [WAYS-1:0]             val  [SETS];
        logic [WAYS-1:0]             dirty[SETS];
        logic [WAYS-1:0]             lck  [SETS];
        logic [WAYS-1:0][RANK_W-1:0] rank [SETS];
    } regs_t;

    regs_t q, d;

    // address fields of the held command
    logic [SET_W-1:0] idx_w;
    logic [TAG_W-1:0] tag_w;
    logic [OFF_W-1:0] off_w;
    logic             nc_w;
    assign idx_w = q.addr[OFF_W +: SET_W];
    assign tag_w = q.addr[ADDR_W-1 -: TAG_W];
    assign off_w = q.addr[OFF_W-1:0];
    assign nc_w  = q.addr[ADDR_W-1];

    // tag compare across the indexed set
    logic             hit_w;
    logic [WAY_W-1:0] hway_w;
    always_comb begin
        hit_w  = 1'b0;
        hway_w = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (q.val[idx_w][w] && q.tag[idx_w][w] == tag_w) begin
                hit_w  = 1'b1;
                hway_w = WAY_W'(w);
            end
        end
    end

    logic                        vfound_w;
    logic [WAY_W-1:0]            vway_w;
    logic [WAYS-1:0][RANK_W-1:0] rank_mru_w, rank_lru_w;

    cc_victim #(.WAYS(WAYS), .RANK_W(RANK_W)) u_victim (
        .way_valid (q.val[idx_w]),
        .way_locked(q.lck[idx_w]),
        .way_rank  (q.rank[idx_w]),
        .found     (vfound_w),
        .way       (vway_w)
    );

    cc_rank #(.WAYS(WAYS), .RANK_W(RANK_W)) u_rank (
        .rank_in (q.rank[idx_w]),
        .sel     (hway_w),
        .promoted(rank_mru_w),
        .demoted (rank_lru_w)
    );

    // way addressed by write-back: the walk pointer during invalidate-all
    logic [SET_W-1:0] wb_set_w;
    logic [WAY_W-1:0] wb_way_w;
    logic             walking_w;
    assign walking_w = (q.op == OP_INVALL);
    assign wb_set_w  = walking_w ? q.walk[WAY_W +: SET_W] : idx_w;
    assign wb_way_w  = walking_w ? q.walk[WAY_W-1:0] : q.way;

    logic             mru_fire_w;
    logic             alloc_w, next_line_w;
    logic [CNT_W-1:0] len_eff_w, span_w;

    always_comb begin
        d           = q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_be      = '0;
        mem_wline   = '0;
        mru_fire_w  = 1'b0;
        alloc_w     = 1'b0;
        next_line_w = 1'b0;
        len_eff_w   = (cmd_len == '0) ? CNT_W'(1) : CNT_W'(cmd_len);
        span_w      = CNT_W'(cmd_addr[OFF_W-1:0]) + len_eff_w - 1'b1;

        case (q.st)
            S_IDLE: if (cmd_valid) begin
                d.op    = op_e'(cmd_op);
                d.addr  = cmd_addr;
                d.wbyte = cmd_wbyte;
                d.lock  = cmd_lock;
                d.flush = cmd_flush;
                d.cb    = copy_back;
                d.miss  = 1'b0;
                d.fail  = 1'b0;
                d.walk  = '0;
                d.lines = (span_w >> OFF_W) + 1'b1;
                d.st    = (op_e'(cmd_op) == OP_INVALL) ? S_WALK : S_LOOK;
            end

            S_LOOK: if (nc_w) begin
                d.miss = 1'b1;
                if (q.op == OP_READ)       d.st = S_NCRD;
                else if (q.op == OP_WRITE) d.st = S_MWR;
                else                       d.st = S_DONE;
            end else begin
                case (q.op)
                    OP_READ: if (hit_w) begin
                        d.rline = q.data[idx_w][hway_w];
                        mru_fire_w = 1'b1;
                        d.st = S_DONE;
                    end else if (vfound_w) alloc_w = 1'b1;
                    else begin
                        d.fail = 1'b1;
                        d.miss = 1'b1;
                        d.st   = S_DONE;
                    end
                    OP_WRITE: if (hit_w) begin
                        d.data[idx_w][hway_w][{off_w, 3'b000} +: 8] = q.wbyte;
                        d.dirty[idx_w][hway_w] = q.cb;
                        mru_fire_w = 1'b1;
                        d.st = q.cb ? S_DONE : S_MWR;
                    end else if (q.cb && vfound_w) alloc_w = 1'b1;
                    else begin
                        d.fail = !vfound_w;
                        d.miss = 1'b1;
                        d.st   = S_MWR;
                    end
                    OP_PRELOAD: if (hit_w) begin
                        if (q.lock) d.lck[idx_w][hway_w] = 1'b1;
                        mru_fire_w  = 1'b1;
                        next_line_w = 1'b1;
                    end else if (vfound_w) alloc_w = 1'b1;
                    else begin
                        d.fail = 1'b1;
                        d.miss = 1'b1;
                        next_line_w = 1'b1;
                    end
                    OP_UNLOCK: begin
                        if (hit_w) d.lck[idx_w][hway_w] = 1'b0;
                        else       d.miss = 1'b1;
                        d.st = S_DONE;
                    end
                    OP_INVAL: if (hit_w && q.dirty[idx_w][hway_w] && q.flush) begin
                        d.way = hway_w;
                        d.st  = S_WB;
                    end else begin
                        if (hit_w) begin
                            d.val[idx_w][hway_w]   = 1'b0;
                            d.lck[idx_w][hway_w]   = 1'b0;
                            d.dirty[idx_w][hway_w] = 1'b0;
                            d.rank[idx_w] = rank_lru_w;
                        end else d.miss = 1'b1;
                        d.st = S_DONE;
                    end
                    default: d.st = S_DONE;
                endcase
            end

            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = '1;
                mem_addr  = {q.tag[wb_set_w][wb_way_w], wb_set_w, OFF_W'(0)};
                mem_wline = q.data[wb_set_w][wb_way_w];
                if (mem_ack) begin
                    d.dirty[wb_set_w][wb_way_w] = 1'b0;
                    d.st = walking_w ? S_WALK : S_LOOK;
                end
            end

            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {tag_w, idx_w, OFF_W'(0)};
                if (mem_ack) begin
                    d.data[idx_w][q.way]  = mem_rline;
                    d.tag[idx_w][q.way]   = tag_w;
                    d.val[idx_w][q.way]   = 1'b1;
                    d.dirty[idx_w][q.way] = 1'b0;
                    d.lck[idx_w][q.way]   = 1'b0;
                    d.st = S_LOOK;
                end
            end

            S_MWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.addr[ADDR_W-1:OFF_W], OFF_W'(0)};
                mem_be    = LINE_BYTES'(1) << off_w;
                mem_wline = {LINE_BYTES{q.wbyte}};
                if (mem_ack) d.st = S_DONE;
            end

            S_NCRD: begin
                mem_req  = 1'b1;
                mem_addr = {q.addr[ADDR_W-1:OFF_W], OFF_W'(0)};
                if (mem_ack) begin
                    d.rline = mem_rline;
                    d.st    = S_DONE;
                end
            end

            S_WALK: if (q.val[wb_set_w][wb_way_w] && q.dirty[wb_set_w][wb_way_w] && q.flush) begin
                d.st = S_WB;
            end else begin
                d.val[wb_set_w][wb_way_w]   = 1'b0;
                d.lck[wb_set_w][wb_way_w]   = 1'b0;
                d.dirty[wb_set_w][wb_way_w] = 1'b0;
                d.walk = q.walk + 1'b1;
                if (q.walk == '1) d.st = S_DONE;
            end

            S_DONE: d.st = S_IDLE;

            default: d.st = S_IDLE;
        endcase

        if (alloc_w) begin
            d.miss = 1'b1;
            d.way  = vway_w;
            d.st   = (q.val[idx_w][vway_w] && q.dirty[idx_w][vway_w]) ? S_WB : S_FILL;
        end
        if (mru_fire_w) d.rank[idx_w] = rank_mru_w;
        if (next_line_w) begin
            d.addr  = {q.addr[ADDR_W-1:OFF_W] + 1'b1, OFF_W'(0)};
            d.lines = q.lines - 1'b1;
            d.st    = (q.lines <= CNT_W'(1)) ? S_DONE : S_LOOK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= S_IDLE;
            q.op    <= OP_READ;
            q.addr  <= '0;
            q.wbyte <= '0;
            q.lock  <= 1'b0;
            q.flush <= 1'b0;
            q.cb    <= 1'b0;
            q.miss  <= 1'b0;
            q.fail  <= 1'b0;
            q.lines <= '0;
            q.walk  <= '0;
            q.way   <= '0;
            q.rline <= '0;
            for (int s = 0; s < SETS; s++) begin
                q.val[s]   <= '0;
                q.dirty[s] <= '0;
                q.lck[s]   <= '0;
                q.rank[s]  <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    q.tag[s][w]  <= '0;
                    q.data[s][w] <= '0;
                end
            end
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == S_IDLE);
    assign cmd_done  = (q.st == S_DONE);
    assign cmd_hit   = !q.miss;
    assign cmd_fail  = q.fail;
    assign rd_line   = q.rline;

    // a completed fill never lands in a locked way
    assert_fill_unlocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FILL && mem_ack) |-> !q.lck[idx_w][q.way]);

    // a lookup that finds the whole set locked never proceeds to a fill
    assert_locked_set_no_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_LOOK && !nc_w && !hit_w && !vfound_w) |=> (q.st != S_FILL));

    // a hit access leaves its way at the top rank
    assert_mru_rank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mru_fire_w |=> (q.rank[$past(idx_w)][$past(hway_w)] == RANK_W'(WAYS)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: tb/tb_lock_cache_ctrl.sv
module tb_lock_cache_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_wbyte = '0;
    logic [7:0]  cmd_len = '0;
    logic        cmd_lock = 1'b0;
    logic        cmd_flush = 1'b0;
    logic        copy_back = 1'b0;
    logic        cmd_done, cmd_hit, cmd_fail;
    logic [31:0] rd_line;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wline, mem_rline;
    logic        mem_ack;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lock_cache_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wbyte(cmd_wbyte), .cmd_len(cmd_len),
        .cmd_lock(cmd_lock), .cmd_flush(cmd_flush), .copy_back(copy_back),
        .cmd_done(cmd_done), .cmd_hit(cmd_hit), .cmd_fail(cmd_fail), .rd_line(rd_line),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] init_line(input logic [15:0] a);
        return 32'hC0DE0000 | {24'h0, a[9:2]};
    endfunction

    function automatic logic [31:0] put_byte(input logic [31:0] l, input logic [15:0] a,
                                              input logic [7:0] b);
        logic [31:0] r = l;
        r[{a[1:0], 3'b000} +: 8] = b;
        return r;
    endfunction

    // memory model: 256 lines, acknowledge after three request cycles
    logic [31:0] mem [256];
    logic [1:0]  lat;
    assign mem_rline = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_line(16'(i << 2));
            mem_ack <= 1'b0;
            lat     <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (lat == 2'd2) begin
                    mem_ack <= 1'b1;
                    lat     <= '0;
                    if (mem_we)
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wline[b*8 +: 8];
                end else lat <= lat + 1'b1;
            end else lat <= '0;
        end
    end

    // handshake monitor
    logic        hs_err, prev_req, prev_ack;
    logic [15:0] prev_addr;
    always @(posedge clk) begin
        if (!rst_n) begin
            hs_err <= 1'b0; prev_req <= 1'b0; prev_ack <= 1'b0; prev_addr <= '0;
        end else begin
            if (prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr)) hs_err <= 1'b1;
            prev_req  <= mem_req;
            prev_ack  <= mem_ack;
            prev_addr <= mem_addr;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    logic        r_hit, r_fail;
    logic [31:0] r_line;

    task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [7:0] b,
                         input logic [7:0] len, input logic lk, input logic fl);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wbyte = b;
        cmd_len = len; cmd_lock = lk; cmd_flush = fl;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_done) @(negedge clk);
        r_hit = cmd_hit; r_fail = cmd_fail; r_line = rd_line;
    endtask

    task automatic rd(input logic [15:0] a);      issue(3'd0, a, 8'h0, 8'h0, 1'b0, 1'b0); endtask
    task automatic wr(input logic [15:0] a, input logic [7:0] b); issue(3'd1, a, b, 8'h0, 1'b0, 1'b0); endtask
    task automatic clear_all();                   issue(3'd5, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0); endtask

    task automatic t_reset();
        chk("R11 ready after reset", 32'(cmd_ready), 32'd1);
        chk("R11 done low after reset", 32'(cmd_done), 32'd0);
        chk("R13 no request after reset", 32'(mem_req), 32'd0);
    endtask

    task automatic t_read();
        copy_back = 1'b0; clear_all();
        rd(16'h0010);
        chk("R2 miss line", r_line, init_line(16'h0010));
        chk("R2 miss hit flag", 32'(r_hit), 32'd0);
        @(negedge clk);
        chk("R11 done one cycle", 32'(cmd_done), 32'd0);
        chk("R11 ready again", 32'(cmd_ready), 32'd1);
        rd(16'h0010);
        chk("R2 repeat hit", 32'(r_hit), 32'd1);
        chk("R2 repeat line", r_line, init_line(16'h0010));
    endtask

    task automatic t_write_through();
        logic [31:0] e1, e2;
        copy_back = 1'b0; clear_all();
        rd(16'h0010);
        wr(16'h0011, 8'hAB);
        e1 = put_byte(init_line(16'h0010), 16'h0011, 8'hAB);
        chk("R5 wt hit reaches memory", mem[8'h04], e1);
        rd(16'h0010);
        chk("R3 merged lane", r_line, e1);
        chk("R3 hit after write", 32'(r_hit), 32'd1);
        wr(16'h0086, 8'h5A);
        e2 = put_byte(init_line(16'h0086), 16'h0086, 8'h5A);
        chk("R5 wt miss memory", mem[8'h21], e2);
        rd(16'h0084);
        chk("R5 wt miss not allocated", 32'(r_hit), 32'd0);
    endtask

    task automatic t_copy_back();
        logic [31:0] e;
        copy_back = 1'b1; clear_all();
        wr(16'h0020, 8'h77);
        e = put_byte(init_line(16'h0020), 16'h0020, 8'h77);
        chk("R3 cb miss leaves memory", mem[8'h08], init_line(16'h0020));
        rd(16'h0020);
        chk("R3 cb allocated line", r_line, e);
        chk("R3 cb allocated hit", 32'(r_hit), 32'd1);
        rd(16'h0030); rd(16'h0040); rd(16'h0050); rd(16'h0060);
        chk("R6 dirty victim written back", mem[8'h08], e);
    endtask

    task automatic t_lru();
        copy_back = 1'b0; clear_all();
        rd(16'h0108); rd(16'h0118); rd(16'h0128); rd(16'h0138);
        rd(16'h0108);
        chk("R4 resident hit", 32'(r_hit), 32'd1);
        rd(16'h0148);
        rd(16'h0108);
        chk("R4 recently used kept", 32'(r_hit), 32'd1);
        rd(16'h0118);
        chk("R4 least recent evicted", 32'(r_hit), 32'd0);
    endtask

    task automatic t_lock();
        logic [31:0] e;
        copy_back = 1'b1; clear_all();
        issue(3'd2, 16'h0204, 8'h0, 8'd1, 1'b1, 1'b0);
        issue(3'd2, 16'h0214, 8'h0, 8'd1, 1'b1, 1'b0);
        issue(3'd2, 16'h0224, 8'h0, 8'd1, 1'b1, 1'b0);
        issue(3'd2, 16'h0234, 8'h0, 8'd1, 1'b1, 1'b0);
        rd(16'h0244);
        chk("R1 all locked read fails", 32'(r_fail), 32'd1);
        wr(16'h0244, 8'h99);
        e = put_byte(init_line(16'h0244), 16'h0244, 8'h99);
        chk("R1 all locked write fails", 32'(r_fail), 32'd1);
        chk("R1 all locked write to memory", mem[8'h91], e);
        rd(16'h0204);
        chk("R1 locked line kept", 32'(r_hit), 32'd1);
        issue(3'd3, 16'h0254, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R8 unlock miss", 32'(r_hit), 32'd0);
        issue(3'd3, 16'h0214, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R8 unlock hit", 32'(r_hit), 32'd1);
        rd(16'h0244);
        chk("R8 allocation after unlock", 32'(r_fail), 32'd0);
        chk("R1 fetched line", r_line, e);
        rd(16'h0214);
        chk("R8 unlocked way was victim", 32'(r_hit), 32'd0);
    endtask

    task automatic t_preload();
        copy_back = 1'b0; clear_all();
        issue(3'd2, 16'h0302, 8'h0, 8'd5, 1'b0, 1'b0);
        rd(16'h0304); chk("R7 second line present", 32'(r_hit), 32'd1);
        rd(16'h0300); chk("R7 first line present", 32'(r_hit), 32'd1);
        rd(16'h0308); chk("R7 third line absent", 32'(r_hit), 32'd0);
        issue(3'd2, 16'h0402, 8'h0, 8'd0, 1'b0, 1'b0);
        rd(16'h0400); chk("R7 zero length one line", 32'(r_hit), 32'd1);
        rd(16'h0404); chk("R7 zero length no more", 32'(r_hit), 32'd0);
        issue(3'd2, 16'h0503, 8'h0, 8'd2, 1'b0, 1'b0);
        rd(16'h0504); chk("R7 straddle second line", 32'(r_hit), 32'd1);
    endtask

    task automatic t_inval();
        logic [31:0] e;
        copy_back = 1'b1; clear_all();
        wr(16'h0600, 8'h11);
        issue(3'd4, 16'h0600, 8'h0, 8'h0, 1'b0, 1'b1);
        e = put_byte(init_line(16'h0600), 16'h0600, 8'h11);
        chk("R9 flush writes back", mem[8'h80], e);
        rd(16'h0600);
        chk("R9 line invalid", 32'(r_hit), 32'd0);
        wr(16'h0610, 8'h22);
        issue(3'd4, 16'h0610, 8'h0, 8'h0, 1'b0, 1'b0);
        chk("R9 no flush keeps memory", mem[8'h84], init_line(16'h0610));
        rd(16'h0610);
        chk("R9 dropped data", r_line, init_line(16'h0610));
    endtask

    task automatic t_invall();
        copy_back = 1'b1; clear_all();
        wr(16'h0700, 8'h33);
        wr(16'h0714, 8'h44);
        issue(3'd2, 16'h0724, 8'h0, 8'd1, 1'b1, 1'b0);
        issue(3'd5, 16'h0, 8'h0, 8'h0, 1'b0, 1'b1);
        chk("R10 flush line a", mem[8'hC0], put_byte(init_line(16'h0700), 16'h0700, 8'h33));
        chk("R10 flush line b", mem[8'hC5], put_byte(init_line(16'h0714), 16'h0714, 8'h44));
        rd(16'h0724); chk("R10 locked line cleared", 32'(r_hit), 32'd0);
        rd(16'h0700); chk("R10 dirty line cleared", 32'(r_hit), 32'd0);
    endtask

    task automatic t_noncache();
        logic [31:0] e;
        copy_back = 1'b1; clear_all();
        rd(16'h8028);
        chk("R12 bypass read", r_line, init_line(16'h0028));
        chk("R12 bypass hit flag", 32'(r_hit), 32'd0);
        wr(16'h802A, 8'h66);
        e = put_byte(init_line(16'h0028), 16'h002A, 8'h66);
        chk("R12 bypass write", mem[8'h0A], e);
        rd(16'h0028);
        chk("R12 read did not allocate", 32'(r_hit), 32'd0);
        chk("R12 cached sees memory", r_line, e);
        chk("R13 handshake held", 32'(hs_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_write_through();
        t_copy_back();
        t_lru();
        t_lock();
        t_preload();
        t_inval();
        t_invall();
        t_noncache();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule